// File: doc/BRIEF.md
# Bus Polling Liveness Supervisor

This block watches the health of a shared serial management bus on which several power-management devices sit. The same logic runs in every node. A node set to the controller role starts a poll cycle at a fixed interval. In each cycle it asks every enabled target, one by one, for its identifier, and it expects each answer within a reply timeout. A node set to the target role instead watches the requests that come to it. It expects its own identifier to be requested at least once within one and a half poll periods.

All time is measured in ticks of an external timebase strobe, so the clock frequency does not enter the configuration. While the boot-or-recovery flag is high, the controller uses a second, longer reply timeout. This gives slow-recovering targets time to come back. Any missed deadline raises a sticky error trigger toward the power state machine and silences the node. A silenced node sends no requests and gives no answers. Its peers then miss their own deadlines, so the shutdown spreads to every node on the bus. The poll period must be configured to the same value on every node.

Top module: `bus_liveness_sup`

## Requirements
- R1: With `ctrl_role_i`=1 and no error, a poll cycle starts on the tick that completes each run of `period_i` ticks counted from reset. `poll_req_o` is high in the cycle after that tick. A period boundary that falls while a cycle is still running is skipped.
- R2: Within a cycle, the controller strobes `poll_req_o` for one cycle per enabled target. `poll_id_o` carries the target number, and `tgt_en_i` bit k enables target k. Targets are polled in ascending number order. The next strobe follows the cycle in which the matching reply arrives.
- R3: With `boot_mode_i`=0, counting starts in the cycle after a strobe. If no matching reply arrives by the `tmo_norm_i`-th tick, the error trigger rises after that tick. A matching reply in the same cycle as that tick is on time.
- R4: With `boot_mode_i`=1, the timeout of R3 uses `tmo_boot_i` instead of `tmo_norm_i`.
- R5: With `ctrl_role_i`=0, a window of `period_i + floor(period_i/2)` ticks runs from reset or from the last request whose `req_id_i` equals `own_id_i`. The error trigger rises after the tick that ends the window without such a request. A request in the same cycle as that tick is on time.
- R6: A reply whose `rsp_id_i` differs from the addressed target does not advance the sequence or restart the timeout. A request whose `req_id_i` differs from `own_id_i` does not restart the target window.
- R7: A reply that arrives while no request is outstanding has no effect. The next cycle still starts on the period boundary and still begins with the lowest enabled target.
- R8: `err_trig_o` and `silenced_o` stay high from the first violation until reset. While they are high, `poll_req_o` stays low.
- R9: After reset, `err_trig_o`, `silenced_o` and `poll_req_o` are low.
- R10: In the target role, `poll_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_i | input | 1 | Timebase strobe; all timers count it |
| ctrl_role_i | input | 1 | 1 = controller role, 0 = target role |
| boot_mode_i | input | 1 | 1 = boot or safe-recovery, selects long reply timeout |
| period_i | input | CNT_W | Poll period in ticks |
| tmo_norm_i | input | CNT_W | Reply timeout in ticks, normal operation |
| tmo_boot_i | input | CNT_W | Reply timeout in ticks, boot or recovery |
| own_id_i | input | ID_W | This node's identifier in target role |
| tgt_en_i | input | N_TGT | Bit k enables polling of target k |
| req_vld_i | input | 1 | Incoming identifier request strobe |
| req_id_i | input | ID_W | Identifier addressed by the incoming request |
| rsp_vld_i | input | 1 | Incoming reply strobe |
| rsp_id_i | input | ID_W | Identifier carried by the reply |
| poll_req_o | output | 1 | Outgoing poll request strobe |
| poll_id_o | output | ID_W | Target addressed by the poll request |
| err_trig_o | output | 1 | Sticky error trigger to the power state machine |
| silenced_o | output | 1 | Node has stopped taking part on the bus |

## Verification
The controller role is swept over every non-empty four-target enable mask, in both normal and boot mode. This shows whether the order skips exactly the disabled targets and whether the strobe moves on only after the matching reply. Replies with the wrong identifier, and replies that come in between cycles, tell a matching check apart from a mere strobe count. Odd masks answer on the exact deadline tick and even masks stay silent, which locates the timeout edge on both sides. The target role is swept over poll periods one to eight, which tests the 1.5x window rounding, the deadline-tick request and a foreign-identifier request placed just before expiry.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/bls_tick_wdog.sv
// Tick counter with deadline compare. RELOAD=1 restarts it on expiry (period
// timer); RELOAD=0 holds it (one-shot watchdog).
module bls_tick_wdog #(
  parameter int LIM_W  = 8,
  parameter bit RELOAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             kick,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  logic [LIM_W-1:0] cnt_q, cnt_d, hold_val;
  logic [LIM_W:0]   cnt_inc;
  logic             hit;

  generate
    if (RELOAD) begin : g_reload
      assign hold_val = '0;
    end else begin : g_saturate
      assign hold_val = cnt_q;
    end
  endgenerate

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hit     = cnt_inc >= {1'b0, limit};
  assign expire  = en & tick & ~kick & hit;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (kick) cnt_d = '0;
    else if (tick) cnt_d = hit ? hold_val : cnt_inc[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bls_poll_seq.sv
// Walks enabled targets in ascending order, one request outstanding at a time.
module bls_poll_seq
  import bls_pkg::*;
#(
  parameter int N_TGT = 4,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [N_TGT-1:0] tgt_en,
  input  logic             rsp_vld,
  input  logic [ID_W-1:0]  rsp_id,
  output logic             issue,
  output logic             waiting,
  output logic             match,
  output logic [ID_W-1:0]  cur_id
);
  sq_state_t       st_q, st_d;
  logic [ID_W-1:0] cur_q, cur_d;
  logic [ID_W-1:0] first_id, nxt_id;
  logic            has_first, has_nxt;

  always_comb begin
    first_id  = '0;
    has_first = 1'b0;
    nxt_id    = '0;
    has_nxt   = 1'b0;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (tgt_en[i]) begin
        first_id  = ID_W'(i);
        has_first = 1'b1;
        if (i > int'(cur_q)) begin
          nxt_id  = ID_W'(i);
          has_nxt = 1'b1;
        end
      end
    end
  end

  assign issue   = (st_q == SQ_ISSUE);
  assign waiting = (st_q == SQ_WAIT);
  assign match   = waiting & rsp_vld & (rsp_id == cur_q);
  assign cur_id  = cur_q;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    if (!run) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start && has_first) begin
            st_d  = SQ_ISSUE;
            cur_d = first_id;
          end
        end
        SQ_ISSUE: st_d = SQ_WAIT;
        SQ_WAIT: begin
          if (match) begin
            if (has_nxt) begin
              st_d  = SQ_ISSUE;
              cur_d = nxt_id;
            end else begin
              st_d = SQ_IDLE;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
    end
  end
endmodule

// File: rtl/bus_liveness_sup.sv
module bus_liveness_sup #(
  parameter int N_TGT = 4,
  parameter int CNT_W = 12,
  parameter int ID_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctrl_role_i,
  input  logic             boot_mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] tmo_norm_i,
  input  logic [CNT_W-1:0] tmo_boot_i,
  input  logic [ID_W-1:0]  own_id_i,
  input  logic [N_TGT-1:0] tgt_en_i,
  input  logic             req_vld_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             rsp_vld_i,
  input  logic [ID_W-1:0]  rsp_id_i,
  output logic             poll_req_o,
  output logic [ID_W-1:0]  poll_id_o,
  output logic             err_trig_o,
  output logic             silenced_o
);
  localparam int WIN_W = CNT_W + 1;

  logic             err_q, err_d;
  logic             ctl_run, tgt_run;
  logic             per_start, rsp_exp, tgt_exp, tgt_kick;
  logic             seq_issue, seq_wait, seq_match;
  logic [CNT_W-1:0] tmo_sel;
  logic [WIN_W-1:0] tgt_window;

  assign ctl_run    = ctrl_role_i & ~err_q;
  assign tgt_run    = ~ctrl_role_i & ~err_q;
  assign tmo_sel    = boot_mode_i ? tmo_boot_i : tmo_norm_i;
  assign tgt_window = {1'b0, period_i} + {2'b00, period_i[CNT_W-1:1]};
  assign tgt_kick   = req_vld_i & (req_id_i == own_id_i);

  bls_tick_wdog #(.LIM_W(CNT_W), .RELOAD(1'b1)) u_period (
    .clk(clk), .rst_n(rst_n), .en(ctl_run), .tick(tick_i), .kick(1'b0),
    .limit(period_i), .expire(per_start)
  );

  bls_poll_seq #(.N_TGT(N_TGT), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(ctl_run), .start(per_start),
    .tgt_en(tgt_en_i), .rsp_vld(rsp_vld_i), .rsp_id(rsp_id_i),
    .issue(seq_issue), .waiting(seq_wait), .match(seq_match), .cur_id(poll_id_o)
  );

  bls_tick_wdog #(.LIM_W(CNT_W), .RELOAD(1'b0)) u_reply (
    .clk(clk), .rst_n(rst_n), .en(seq_wait & ~err_q), .tick(tick_i),
    .kick(seq_match), .limit(tmo_sel), .expire(rsp_exp)
  );

  bls_tick_wdog #(.LIM_W(WIN_W), .RELOAD(1'b0)) u_target (
    .clk(clk), .rst_n(rst_n), .en(tgt_run), .tick(tick_i), .kick(tgt_kick),
    .limit(tgt_window), .expire(tgt_exp)
  );

  assign err_d = err_q | rsp_exp | tgt_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign poll_req_o = seq_issue & ctl_run;
  assign err_trig_o = err_q;
  assign silenced_o = err_q;
endmodule

// File: rtl/bls_sup_chk.sv
module bls_sup_chk #(
  parameter int N_TGT = 4,
  parameter int ID_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             ctrl_role_i,
  input logic [N_TGT-1:0] tgt_en_i,
  input logic             poll_req_o,
  input logic [ID_W-1:0]  poll_id_o,
  input logic             err_trig_o,
  input logic             silenced_o
);
  logic [N_TGT-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= tgt_en_i;
  end

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_trig_o |=> err_trig_o);

  a_r8_silent_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    silenced_o |-> !poll_req_o);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req_o |=> !poll_req_o);

  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req_o |-> en_q[poll_id_o]);

  a_r3_err_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_trig_o) |-> $past(tick_i));

  a_r10_target_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_role_i && !$past(ctrl_role_i)) |-> !poll_req_o);
endmodule

bind bus_liveness_sup bls_sup_chk #(.N_TGT(N_TGT), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctrl_role_i(ctrl_role_i),
  .tgt_en_i(tgt_en_i), .poll_req_o(poll_req_o), .poll_id_o(poll_id_o),
  .err_trig_o(err_trig_o), .silenced_o(silenced_o)
);

// File: tb/bus_liveness_sup_tb_top.sv
module bus_liveness_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 6;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic          tick, role, boot, req_vld, rsp_vld;
  logic [CW-1:0] period, tmo_n, tmo_b;
  logic [IW-1:0] own_id, req_id, rsp_id;
  logic [NT-1:0] mask;
  logic          preq, err, sil;
  logic [IW-1:0] pid;
  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  bus_liveness_sup #(.N_TGT(NT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctrl_role_i(role),
    .boot_mode_i(boot), .period_i(period), .tmo_norm_i(tmo_n),
    .tmo_boot_i(tmo_b), .own_id_i(own_id), .tgt_en_i(mask),
    .req_vld_i(req_vld), .req_id_i(req_id), .rsp_vld_i(rsp_vld),
    .rsp_id_i(rsp_id), .poll_req_o(preq), .poll_id_o(pid),
    .err_trig_o(err), .silenced_o(sil)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int first_en(input int m);
    for (int i = 0; i < NT; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int next_en(input int m, input int cur);
    for (int i = cur + 1; i < NT; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic rv, input int rid,
                     input logic qv, input int qid);
    tick    = tk;
    rsp_vld = rv;
    rsp_id  = IW'(rid);
    req_vld = qv;
    req_id  = IW'(qid);
    @(posedge clk);
    #1;
    tick    = 1'b0;
    rsp_vld = 1'b0;
    req_vld = 1'b0;
  endtask

  task automatic do_reset(input logic r, input int p, input int m,
                          input logic b, input int own);
    rst_n   = 1'b0;
    role    = r;
    period  = CW'(p);
    tmo_n   = CW'(2);
    tmo_b   = CW'(5);
    mask    = NT'(m);
    boot    = b;
    own_id  = IW'(own);
    tick    = 1'b0;
    rsp_vld = 1'b0;
    req_vld = 1'b0;
    rsp_id  = '0;
    req_id  = '0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int id, nx, fst, tmo;
    // Controller role sweep: every non-empty mask, normal and boot timeout.
    for (int b = 0; b < 2; b++) begin
      for (int m = 1; m < (1 << NT); m++) begin
        do_reset(1'b1, 3, m, b[0], 0);
        chk("R9 err after reset", int'(err), 0);
        chk("R9 silenced after reset", int'(sil), 0);
        chk("R9 req after reset", int'(preq), 0);
        fst = first_en(m);
        for (int k = 1; k <= 3; k++) begin
          cyc(1'b1, 1'b0, 0, 1'b0, 0);
          if (k < 3) chk("R1 no early start", int'(preq), 0);
        end
        chk("R1 start on period", int'(preq), 1);
        chk("R2 lowest id first", int'(pid), fst);
        id = fst;
        while (id >= 0) begin
          cyc(1'b0, 1'b0, 0, 1'b0, 0);
          chk("R2 one strobe per target", int'(preq), 0);
          cyc(1'b0, 1'b1, (id + 1) % NT, 1'b0, 0);
          chk("R6 wrong reply no advance", int'(preq), 0);
          cyc(1'b0, 1'b1, id, 1'b0, 0);
          nx = next_en(m, id);
          if (nx >= 0) begin
            chk("R2 next strobe", int'(preq), 1);
            chk("R2 ascending id", int'(pid), nx);
          end else begin
            chk("R2 cycle ends", int'(preq), 0);
          end
          id = nx;
        end
        cyc(1'b0, 1'b1, fst, 1'b0, 0);
        chk("R7 stray reply ignored", int'(preq), 0);
        for (int k = 1; k <= 3; k++) begin
          cyc(1'b1, 1'b0, 0, 1'b0, 0);
          if (k < 3) chk("R1 period spacing", int'(preq), 0);
        end
        chk("R1 second start", int'(preq), 1);
        chk("R7 restart at lowest id", int'(pid), fst);
        tmo = (b != 0) ? 5 : 2;
        cyc(1'b0, 1'b0, 0, 1'b0, 0);
        cyc(1'b1, 1'b1, (fst + 1) % NT, 1'b0, 0);
        chk("R6 wrong reply no kick", int'(err), 0);
        for (int k = 2; k < tmo; k++) begin
          cyc(1'b1, 1'b0, 0, 1'b0, 0);
          chk((b != 0) ? "R4 long timeout holds" : "R3 inside timeout",
              int'(err), 0);
        end
        if (m % 2 == 1) begin
          cyc(1'b1, 1'b1, fst, 1'b0, 0);
          chk("R3 reply on deadline tick", int'(err), 0);
        end else begin
          cyc(1'b1, 1'b0, 0, 1'b0, 0);
          chk((b != 0) ? "R4 boot timeout expiry" : "R3 timeout expiry",
              int'(err), 1);
          chk("R8 silenced on error", int'(sil), 1);
          for (int k = 1; k < 10; k++) begin
            cyc(1'b1, 1'b1, k % NT, 1'b0, 0);
            chk("R8 no request when silenced", int'(preq), 0);
            chk("R8 error sticky", int'(err), 1);
          end
        end
      end
    end

    // Target role sweep over poll periods.
    for (int p = 1; p <= 8; p++) begin
      int w;
      w = p + p / 2;
      do_reset(1'b0, p, 15, 1'b0, 2);
      for (int k = 1; k < w; k++) begin
        cyc(1'b1, 1'b0, 0, 1'b0, 0);
        chk("R5 inside window", int'(err), 0);
        chk("R10 target sends no request", int'(preq), 0);
      end
      cyc(1'b1, 1'b0, 0, 1'b1, 2);
      chk("R5 request on deadline tick", int'(err), 0);
      for (int k = 1; k < w; k++) begin
        cyc(1'b1, 1'b1, 2, 1'b0, 0);
        chk("R5 window restarted", int'(err), 0);
      end
      cyc(1'b0, 1'b0, 0, 1'b1, 1);
      chk("R6 foreign request", int'(err), 0);
      cyc(1'b1, 1'b0, 0, 1'b0, 0);
      chk("R5 window expiry", int'(err), 1);
      chk("R8 target silenced", int'(sil), 1);
      cyc(1'b1, 1'b0, 0, 1'b1, 2);
      chk("R8 target error sticky", int'(err), 1);
      chk("R10 no request after error", int'(preq), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule